// File: doc/BRIEF.md
# Packed-BCD Time-of-Day Counter with Dual Capture

This block keeps a calendar time, from microseconds up to the year, as packed BCD digits. A divider turns the system clock into a one-microsecond tick. On every tick the time advances, and each digit rolls over at its own limit: microsecond, second and minute digits behave as usual, hours wrap after 23, the day of year wraps after 365 or 366, and the year wraps after 9999. Software reaches the block through a small register bus. It can preset each field, start and stop counting, and arm the counter so that it starts on the next rising edge of an external one-pulse-per-second reference.

Software reads the time as five 16-bit words. Each word holds up to four BCD digits, and one nibble carries status. Reading word 0 returns the live value in the same cycle and, at the same moment, freezes all five words into a snapshot. The other four words are then read from that snapshot, so a multi-word read stays coherent even when a carry ripples through the fields in between. A second, independent capture set is frozen on the rising edge of a synchronized external event input. Each such capture raises an interrupt request, which stays set until software clears it.

Top module: `bcd_tod_clock`

## Requirements
- R1: After reset the time is 00:00:00.000000 on day 001 of year 0000. The counter is stopped and not armed, the interrupt and the overrun flag are clear, and both capture sets and the control word read 0.
- R2: While running, the time advances by one microsecond every CLK_DIV clock cycles. The count starts CLK_DIV cycles after the run bit is set. Each microsecond digit counts 0 to 9 and carries into the next digit.
- R3: Seconds and minutes roll from 59 to 00 and carry into the next field. Hours roll from 23 to 00 and carry into the day.
- R4: The day of year runs from 001 to its last day, then wraps to 001 and increments the year. The last day is 366 in a leap year and 365 otherwise. With LEAP_MODE=1 a year is a leap year when it is divisible by 4, except for century years, which must be divisible by 400. With LEAP_MODE=0 every year divisible by 4 is a leap year. Year 9999 wraps to 0000.
- R5: The words have this layout. Word 0 holds the four low microsecond digits. Word 1 holds the two high microsecond digits in [7:0] and the seconds in [15:8]. Word 2 holds the minutes in [7:0] and the hours in [15:8]. Word 3 holds the day of year in [11:0] and the status nibble in [15:12]. Word 4 holds the year. A read of address 0 returns live word 0 in the same cycle and freezes all five words; reads of addresses 1 to 4 return that frozen snapshot.
- R6: A write to address 0 to 4 presets the fields of that word; the status nibble of word 3 ignores writes. A write to address 10 sets the run state from bit 0. While stopped, the time does not change.
- R7: A write to address 10 with bit 1 set arms the counter. The next synchronized rising edge on the pulse-per-second input then starts the counter and clears the arm flag. A pulse that arrives while the counter is not armed has no effect.
- R8: A synchronized rising edge on the event input copies all five live words, status included, into the event set, which is read at addresses 5 to 9 (word 0 to word 4). The same edge sets the interrupt output.
- R9: The interrupt stays set until a write to address 10 with bit 2 set clears both the interrupt and the overrun flag. If an event arrives while the interrupt is pending, the event set is overwritten and the overrun flag is set.
- R10: The status nibble is {overrun, interrupt pending, armed, running}, from bit 3 down to bit 0. It appears in word 3 [15:12] and in bits [3:0] of a read of address 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; freezes the snapshot at address 0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| event_in | input | 1 | Asynchronous event input |
| pps_in | input | 1 | Asynchronous one-pulse-per-second reference |
| irq | output | 1 | Interrupt request from an event capture |

## Verification
The main instance is built with CLK_DIV=1 and LEAP_MODE=1. At that setting one tick falls in every clock cycle, so the bench can run many rollover cases in a few cycles each. These cases are a sweep of all 24 hours across the day boundary, ends of years around century and 400-year leap points, and the 9999 wrap. A second instance shares the same bus with CLK_DIV=3, which exposes the divider's phase and the exact cycle on which counting starts. The bench predicts every value from an integer calendar model of its own.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
   localparam int WORD_W  = 16;
   localparam int N_WORDS = 5;
   localparam int FLAT_W  = WORD_W * N_WORDS;
   localparam logic [3:0] ADDR_CTRL = 4'd10;
   localparam logic [3:0] ADDR_EVT0 = 4'd5;

   typedef struct packed {
      logic [15:0] year;
      logic [11:0] day;
      logic [7:0]  hour;
      logic [7:0]  minute;
      logic [7:0]  second;
      logic [23:0] usec;
   } tod_t;

   function automatic logic [FLAT_W-1:0] tod_flat(tod_t t, logic [3:0] st);
      return {t.year, st, t.day, t.hour, t.minute, t.second, t.usec};
   endfunction

   function automatic logic [WORD_W-1:0] word_of(logic [FLAT_W-1:0] f, logic [2:0] i);
      return f[WORD_W*int'(i) +: WORD_W];
   endfunction

   // two BCD digits (tens, units) form a value divisible by four
   function automatic logic bcd_div4(logic [3:0] t, logic [3:0] u);
      logic [4:0] s;
      s = {t, 1'b0} + {1'b0, u};
      return s[1:0] == 2'b00;
   endfunction
endpackage

// File: rtl/bcd_cell.sv
`timescale 1ns/1ps
module bcd_cell #(
   parameter logic [3:0] TOP = 4'd9
) (
   input  logic       inc,
   input  logic [3:0] q,
   output logic [3:0] d,
   output logic       co
);
   always_comb begin
      co = inc && (q >= TOP);
      if (!inc)          d = q;
      else if (q >= TOP) d = 4'd0;
      else               d = 4'(q + 4'd1);
   end
endmodule

// File: rtl/tick_gen.sv
`timescale 1ns/1ps
module tick_gen #(
   parameter int CLK_DIV = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

   generate
      if (CLK_DIV == 1) begin : g_direct
         assign tick = run;
      end else begin : g_div
         localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || !run)  cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                 cnt <= cnt + 1'b1;
         end
         assign tick = run && (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/edge_sync.sv
`timescale 1ns/1ps
module edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic [STAGES-1:0] sh;
   logic              prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh   <= '0;
         prev <= 1'b0;
      end else begin
         sh   <= {sh[STAGES-2:0], din};
         prev <= sh[STAGES-1];
      end
   end
   assign rise = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/tod_counter.sv
`timescale 1ns/1ps
module tod_counter
   import tod_pkg::*;
#(
   parameter int LEAP_MODE = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick,
   input  logic [4:0]  load_en,
   input  logic [15:0] load_word,
   output tod_t        q
);
   localparam int US_DIG = 6;
   localparam int YR_DIG = 4;
   localparam int DY_DIG = 3;

   tod_t nxt;
   logic [US_DIG:0]   us_c;
   logic [23:0]       us_d;
   logic              s0_c, s1_c, m0_c, m1_c, h0_c, h1_c_unused;
   logic [3:0]        s0_d, s1_d, m0_d, m1_d, h0_d, h1_d;
   logic              hr_inc, hr_wrap;
   logic              day_inc, day_wrap, yr_inc, is_leap;
   logic [DY_DIG:0]   dy_c;
   logic [11:0]       dy_d, day_last;
   logic [YR_DIG:0]   yr_c;
   logic [15:0]       yr_d;

   // microsecond digit chain
   assign us_c[0] = tick;
   generate
      for (genvar i = 0; i < US_DIG; i++) begin : g_us
         bcd_cell #(.TOP(4'd9)) u_cell (
            .inc(us_c[i]), .q(q.usec[4*i +: 4]), .d(us_d[4*i +: 4]), .co(us_c[i+1]));
      end
   endgenerate

   bcd_cell #(.TOP(4'd9)) u_s0 (.inc(us_c[US_DIG]), .q(q.second[3:0]), .d(s0_d), .co(s0_c));
   bcd_cell #(.TOP(4'd5)) u_s1 (.inc(s0_c),         .q(q.second[7:4]), .d(s1_d), .co(s1_c));
   bcd_cell #(.TOP(4'd9)) u_m0 (.inc(s1_c),         .q(q.minute[3:0]), .d(m0_d), .co(m0_c));
   bcd_cell #(.TOP(4'd5)) u_m1 (.inc(m0_c),         .q(q.minute[7:4]), .d(m1_d), .co(m1_c));

   // hours wrap as a pair at 23
   assign hr_inc  = m1_c;
   assign hr_wrap = hr_inc && (q.hour >= 8'h23);
   bcd_cell #(.TOP(4'd9)) u_h0 (.inc(hr_inc && !hr_wrap), .q(q.hour[3:0]), .d(h0_d), .co(h0_c));
   bcd_cell #(.TOP(4'd2)) u_h1 (.inc(h0_c), .q(q.hour[7:4]), .d(h1_d), .co(h1_c_unused));

   // leap-year rule chosen by parameter
   generate
      if (LEAP_MODE == 1) begin : g_greg
         assign is_leap = (q.year[7:0] == 8'h00) ? bcd_div4(q.year[15:12], q.year[11:8])
                                                 : bcd_div4(q.year[7:4], q.year[3:0]);
      end else begin : g_quad
         assign is_leap = bcd_div4(q.year[7:4], q.year[3:0]);
      end
   endgenerate

   assign day_last = is_leap ? 12'h366 : 12'h365;
   assign day_inc  = hr_wrap;
   assign day_wrap = day_inc && (q.day >= day_last);
   assign dy_c[0]  = day_inc && !day_wrap;
   generate
      for (genvar i = 0; i < DY_DIG; i++) begin : g_day
         bcd_cell #(.TOP(4'd9)) u_cell (
            .inc(dy_c[i]), .q(q.day[4*i +: 4]), .d(dy_d[4*i +: 4]), .co(dy_c[i+1]));
      end
   endgenerate

   assign yr_inc  = day_wrap;
   assign yr_c[0] = yr_inc;
   generate
      for (genvar i = 0; i < YR_DIG; i++) begin : g_yr
         bcd_cell #(.TOP(4'd9)) u_cell (
            .inc(yr_c[i]), .q(q.year[4*i +: 4]), .d(yr_d[4*i +: 4]), .co(yr_c[i+1]));
      end
   endgenerate

   always_comb begin
      nxt.usec   = us_d;
      nxt.second = {s1_d, s0_d};
      nxt.minute = {m1_d, m0_d};
      nxt.hour   = hr_wrap ? 8'h00 : {h1_d, h0_d};
      nxt.day    = day_wrap ? 12'h001 : dy_d;
      nxt.year   = yr_d;
      if (load_en[0]) nxt.usec[15:0]  = load_word;
      if (load_en[1]) begin
         nxt.usec[23:16] = load_word[7:0];
         nxt.second      = load_word[15:8];
      end
      if (load_en[2]) begin
         nxt.minute = load_word[7:0];
         nxt.hour   = load_word[15:8];
      end
      if (load_en[3]) nxt.day  = load_word[11:0];
      if (load_en[4]) nxt.year = load_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q      <= '0;
         q.day  <= 12'h001;
      end else begin
         q <= nxt;
      end
   end

   p_us_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && load_en == 5'd0 && q.usec[3:0] < 4'd9) |=> q.usec[3:0] == $past(q.usec[3:0]) + 4'd1);
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && load_en == 5'd0) |=> $stable(q));
   p_hour_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hr_inc && load_en == 5'd0 && q.hour == 8'h23) |=> q.hour == 8'h00);
   p_year_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (yr_inc && load_en == 5'd0 && q.year == 16'h9999) |=> q.year == 16'h0000);
endmodule

// File: rtl/event_capture.sv
`timescale 1ns/1ps
module event_capture
   import tod_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic              clr,
   input  logic [FLAT_W-1:0] live,
   output logic [FLAT_W-1:0] cap,
   output logic              pend,
   output logic              ovr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap  <= '0;
         pend <= 1'b0;
         ovr  <= 1'b0;
      end else begin
         if (rise) cap <= live;
         if (rise) begin
            pend <= 1'b1;
            ovr  <= (pend && !clr) | (ovr && !clr);
         end else if (clr) begin
            pend <= 1'b0;
            ovr  <= 1'b0;
         end
      end
   end

   p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> pend);
   p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !clr) |=> pend);
   p_ovr_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && pend && !clr) |=> ovr);
endmodule

// File: rtl/bcd_tod_clock.sv
`timescale 1ns/1ps
module bcd_tod_clock
   import tod_pkg::*;
#(
   parameter int CLK_DIV     = 125,
   parameter int SYNC_STAGES = 2,
   parameter int LEAP_MODE   = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [3:0]  bus_addr,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata,
   input  logic        event_in,
   input  logic        pps_in,
   output logic        irq
);
   generate
      if (CLK_DIV < 1)                       begin : g_bad_div  $error("CLK_DIV must be at least 1"); end
      if (SYNC_STAGES < 2)                   begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end
      if (LEAP_MODE < 0 || LEAP_MODE > 1)    begin : g_bad_leap $error("LEAP_MODE must be 0 or 1"); end
   endgenerate

   logic              running, armed, tick, ev_rise, pps_rise, ev_pend, ev_ovr;
   logic              ctrl_wr, clr;
   logic [3:0]        status, ev_idx;
   logic [4:0]        load_en;
   tod_t              now;
   logic [FLAT_W-1:0] live_flat, snap_flat, ev_flat;

   assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
   assign clr     = ctrl_wr && bus_wdata[2];
   assign status  = {ev_ovr, ev_pend, armed, running};
   assign irq     = ev_pend;
   assign ev_idx  = bus_addr - ADDR_EVT0;

   always_comb begin
      for (int i = 0; i < N_WORDS; i++)
         load_en[i] = bus_wr && (bus_addr == 4'(i));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         armed   <= 1'b0;
      end else if (ctrl_wr) begin
         running <= bus_wdata[0];
         armed   <= bus_wdata[1];
      end else if (armed && pps_rise) begin
         running <= 1'b1;
         armed   <= 1'b0;
      end
   end

   tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(running), .tick(tick));

   edge_sync #(.STAGES(SYNC_STAGES)) u_ev_sync (
      .clk(clk), .rst_n(rst_n), .din(event_in), .rise(ev_rise));

   edge_sync #(.STAGES(SYNC_STAGES)) u_pps_sync (
      .clk(clk), .rst_n(rst_n), .din(pps_in), .rise(pps_rise));

   tod_counter #(.LEAP_MODE(LEAP_MODE)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load_en(load_en),
      .load_word(bus_wdata), .q(now));

   assign live_flat = tod_flat(now, status);

   always_ff @(posedge clk) begin
      if (!rst_n)                          snap_flat <= '0;
      else if (bus_rd && bus_addr == 4'd0) snap_flat <= live_flat;
   end

   event_capture u_evt (
      .clk(clk), .rst_n(rst_n), .rise(ev_rise), .clr(clr),
      .live(live_flat), .cap(ev_flat), .pend(ev_pend), .ovr(ev_ovr));

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == 4'd0)            bus_rdata = live_flat[WORD_W-1:0];
      else if (bus_addr < ADDR_EVT0)   bus_rdata = word_of(snap_flat, bus_addr[2:0]);
      else if (bus_addr < ADDR_CTRL)   bus_rdata = word_of(ev_flat, ev_idx[2:0]);
      else if (bus_addr == ADDR_CTRL)  bus_rdata = {12'h000, status};
   end

   p_arm_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && pps_rise && !ctrl_wr) |=> (running && !armed));
   p_snap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 4'd0) |=> snap_flat == $past(live_flat));
   p_no_pps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !running && !ctrl_wr) |=> !running);
endmodule

// File: tb/bcd_tod_clock_tb_top.sv
`timescale 1ns/1ps
module bcd_tod_clock_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = 4'd0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [15:0] bus_wdata = 16'h0;
   logic [15:0] rdata, rdata2;
   logic        event_in = 1'b0, pps_in = 1'b0;
   logic        irq, irq2;

   int total = 0, bad = 0;
   int m_us, m_s, m_mn, m_h, m_d, m_y;

   always #4 clk = ~clk;

   bcd_tod_clock #(.CLK_DIV(1), .SYNC_STAGES(2), .LEAP_MODE(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(rdata), .event_in(event_in), .pps_in(pps_in), .irq(irq));

   bcd_tod_clock #(.CLK_DIV(3), .SYNC_STAGES(2), .LEAP_MODE(0)) dut_div (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(rdata2), .event_in(1'b0), .pps_in(1'b0), .irq(irq2));

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: run did not end, actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [23:0] to_bcd(input int v);
      logic [23:0] r;
      int x;
      x = v;
      for (int i = 0; i < 6; i++) begin
         r[4*i +: 4] = 4'(x % 10);
         x = x / 10;
      end
      return r;
   endfunction

   function automatic bit leap_y(input int y);
      return (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
   endfunction

   function automatic logic [15:0] exp_word(input int idx, input logic [3:0] st);
      logic [23:0] u, s, mn, h, d, y;
      u = to_bcd(m_us); s = to_bcd(m_s); mn = to_bcd(m_mn);
      h = to_bcd(m_h); d = to_bcd(m_d); y = to_bcd(m_y);
      case (idx)
         0: return u[15:0];
         1: return {s[7:0], u[23:16]};
         2: return {h[7:0], mn[7:0]};
         3: return {st, d[11:0]};
         default: return y[15:0];
      endcase
   endfunction

   task automatic adv(input int n);
      for (int k = 0; k < n; k++) begin
         m_us++;
         if (m_us == 1000000) begin m_us = 0; m_s++; end
         if (m_s == 60) begin m_s = 0; m_mn++; end
         if (m_mn == 60) begin m_mn = 0; m_h++; end
         if (m_h == 24) begin m_h = 0; m_d++; end
         if (m_d > (leap_y(m_y) ? 366 : 365)) begin m_d = 1; m_y++; end
         if (m_y == 10000) m_y = 0;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [15:0] d, output logic [15:0] d2);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      d = rdata; d2 = rdata2;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic preset(input int us, input int s, input int mn, input int h, input int d, input int y);
      m_us = us; m_s = s; m_mn = mn; m_h = h; m_d = d; m_y = y;
      for (int i = 0; i < 5; i++) bus_write(4'(i), exp_word(i, 4'hF));
   endtask

   task automatic check_time(input string tag, input logic [3:0] st);
      logic [15:0] v, v2;
      for (int i = 0; i < 5; i++) begin
         bus_read(4'(i), v, v2);
         chk(tag, v, exp_word(i, st));
      end
   endtask

   task automatic run_case(input int us, input int s, input int mn, input int h,
                           input int d, input int y, input int n, input string tag);
      preset(us, s, mn, h, d, y);
      bus_write(4'd10, 16'h0001);
      idle(n);
      bus_write(4'd10, 16'h0000);
      adv(n + 1);
      check_time(tag, 4'h0);
   endtask

   initial begin
      logic [15:0] v, v2;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1: reset state
      m_us = 0; m_s = 0; m_mn = 0; m_h = 0; m_d = 1; m_y = 0;
      check_time("R1 reset time", 4'h0);
      for (int a = 5; a < 11; a++) begin
         bus_read(4'(a), v, v2);
         chk("R1 reset capture/control", v, 16'h0000);
      end
      total++;
      if (irq !== 1'b0) begin bad++; $display("FAIL R1 irq actual=%b expected=0", irq); end

      // R2: plain microsecond counting and digit carries
      run_case(0, 0, 0, 0, 1, 2024, 20, "R2 count");
      for (int n = 0; n < 12; n++) run_case(95, 7, 3, 4, 50, 2024, n, "R2 carry 99->100");
      run_case(999990, 12, 0, 0, 10, 2024, 15, "R2 second carry");

      // R3: minute, hour boundaries, all hours swept
      run_case(999998, 59, 29, 9, 10, 2024, 3, "R3 minute rollover");
      for (int h = 0; h < 24; h++) run_case(999999, 59, 59, h, 100, 2023, 1, "R3 hour sweep");

      // R4: day and year rollover with the 400-year leap rule
      run_case(999998, 59, 59, 23, 365, 2023, 4, "R4 2023 end");
      run_case(999998, 59, 59, 23, 365, 2024, 4, "R4 2024 day366");
      run_case(999998, 59, 59, 23, 366, 2024, 4, "R4 2024 end");
      run_case(999998, 59, 59, 23, 365, 1900, 4, "R4 1900 non-leap");
      run_case(999998, 59, 59, 23, 365, 2000, 4, "R4 2000 leap");
      run_case(999998, 59, 59, 23, 365, 9999, 4, "R4 year wrap");
      run_case(999999, 59, 59, 23, 99, 2023, 1, "R4 day digit carry");

      // R2: divider instance counts one microsecond per three cycles
      preset(0, 0, 0, 0, 1, 2024);
      bus_write(4'd10, 16'h0001);
      idle(29);
      bus_write(4'd10, 16'h0000);
      bus_read(4'd0, v, v2);
      chk("R2 divider CLK_DIV=3", v2, 16'h0010);
      chk("R2 direct CLK_DIV=1", v, 16'h0030);

      // R5: snapshot coherence across a carry while running
      preset(999990, 41, 0, 0, 1, 2024);
      bus_write(4'd10, 16'h0001);
      idle(5);
      adv(5);
      bus_read(4'd0, v, v2);
      chk("R5 live word0", v, exp_word(0, 4'h1));
      idle(20);
      for (int i = 1; i < 5; i++) begin
         bus_read(4'(i), v, v2);
         chk("R5 frozen words", v, exp_word(i, 4'h1));
      end
      bus_write(4'd10, 16'h0000);

      // R6: stopped time holds; status nibble ignores writes
      preset(123456, 7, 8, 9, 222, 2031);
      idle(50);
      check_time("R6 hold when stopped", 4'h0);

      // R7: pulse without arm has no effect
      preset(0, 0, 0, 0, 1, 2024);
      pps_in = 1'b1; idle(6); pps_in = 1'b0; idle(6);
      check_time("R7 pps unarmed", 4'h0);
      // R7: armed start on pulse
      bus_write(4'd10, 16'h0002);
      bus_read(4'd10, v, v2);
      chk("R7 armed status R10", v, 16'h0002);
      idle(5);
      check_time("R7 armed waits", 4'h2);
      pps_in = 1'b1;
      idle(10);
      bus_read(4'd10, v, v2);
      chk("R7 started by pps R10", v, 16'h0001);
      bus_write(4'd10, 16'h0000);
      pps_in = 1'b0;
      adv(9);
      check_time("R7 count after pps", 4'h0);

      // R8: event capture of a stopped time
      preset(654321, 33, 44, 15, 300, 2040);
      event_in = 1'b1; idle(5);
      for (int i = 0; i < 5; i++) begin
         bus_read(4'(5 + i), v, v2);
         chk("R8 event capture", v, exp_word(i, 4'h0));
      end
      total++;
      if (irq !== 1'b1) begin bad++; $display("FAIL R8 irq actual=%b expected=1", irq); end
      bus_read(4'd10, v, v2);
      chk("R8 status pending R10", v, 16'h0004);

      // R9: pending interrupt holds, second event overwrites and sets overrun
      event_in = 1'b0; idle(20);
      total++;
      if (irq !== 1'b1) begin bad++; $display("FAIL R9 irq hold actual=%b expected=1", irq); end
      preset(11, 1, 2, 3, 4, 2050);
      event_in = 1'b1; idle(5);
      for (int i = 0; i < 5; i++) begin
         bus_read(4'(5 + i), v, v2);
         chk("R9 overwrite capture", v, exp_word(i, 4'h4));
      end
      bus_read(4'd10, v, v2);
      chk("R9 overrun status R10", v, 16'h000C);
      check_time("R10 status in word3", 4'hC);
      bus_write(4'd10, 16'h0004);
      bus_read(4'd10, v, v2);
      chk("R9 cleared", v, 16'h0000);
      total++;
      if (irq !== 1'b0) begin bad++; $display("FAIL R9 irq clear actual=%b expected=0", irq); end
      event_in = 1'b0; idle(4);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule